// File: doc/BRIEF.md
# Packet Memory Pointer Port

This block gives a host indirect access to the bytes of packets held in an on-chip packet memory. The host loads a pointer register with the target, the direction, an optional auto-increment and a byte offset. It then reads or writes a data register, which moves data between the host and packet memory at the pointer. Two sources can name the target packet. One is a host-written packet-number register. The other is the packet that the receive queue currently presents at its head.

Reads are served from a prefetch register. That register is refilled on every clock from the address that the pointer is about to hold. As a result, the word at a newly loaded pointer, or at an advanced pointer, is available on the next cycle. Writes go into a short queue that drains into the memory one entry per cycle. The drain stalls while the MAC side holds the memory. A pending flag in the pointer register tells the host when queued writes have landed. The host must see the flag clear before it repoints for a read.

Top module: `pkt_mem_port`

## Requirements
- R1: After reset the pointer register reads 0x0000, the packet-number register reads 0 and the pending flag (pointer bit 11) is 0.
- R2: Pointer bit 15 set selects the packet numbered by the `rx_head_pkt` input. Bit 15 clear selects the packet named by the low bits of the packet-number register.
- R3: A write to the pointer register (host_sel 0) loads bit 14 (auto-increment), bit 13 (1 = read direction, 0 = write direction) and bits 10:0 (byte offset). On read-back, bit 12 is always 0 and bit 11 shows only the pending flag, whatever value was written to those two bits.
- R4: With auto-increment on, each accepted data access advances the offset by 2 for a 16-bit access (host_wide 0) and by 4 for a 32-bit access (host_wide 1). The offset wraps modulo 2048. With auto-increment off, the offset does not change.
- R5: A data register read (host_sel 1) returns the word at the pointer from the cycle after the pointer was loaded or advanced. A 32-bit read returns the whole 32-bit word and ignores offset bits 1:0. A 16-bit read returns bits 15:0 of the word in host_rdata[15:0] when offset bit 1 is 0, and bits 31:16 when it is 1, with host_rdata[31:16] zero.
- R6: A 16-bit data write places host_wdata[15:0] in bits 15:0 of the addressed word when offset bit 1 is 0, and in bits 31:16 when it is 1. The other half of the word is left unchanged. A 32-bit write replaces the whole word.
- R7: Pointer bit 11 reads 1 while the write queue holds any entry. While `mac_hold` is low the queue retires one entry per cycle. While `mac_hold` is high it retires none.
- R8: A data write that arrives while the write queue is full (4 entries) is dropped: nothing is stored and the offset does not advance.
- R9: A data write while the pointer is in read direction is ignored: it queues nothing and does not advance the offset. A data read while the pointer is in write direction does not advance the offset.
- R10: A write to host_sel 2 loads a 6-bit packet number from host_wdata[5:0], and reading host_sel 2 returns it in host_rdata[5:0]. Reading host_sel 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 2 | Register select: 0 pointer, 1 data, 2 packet number, 3 none |
| host_we | input | 1 | Host write strobe for the selected register |
| host_re | input | 1 | Host read strobe for the selected register |
| host_wide | input | 1 | 1 for a 32-bit data access, 0 for a 16-bit one |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read value of the selected register |
| rx_head_pkt | input | 2 | Packet number at the head of the receive queue |
| mac_hold | input | 1 | MAC owns the memory this cycle; the write queue does not drain |

## Verification
Register read-back appears on host_rdata in the same cycle as the select. A pointer load or an offset advance shows on the following cycle, and the prefetched word follows on the edge that commits the pointer change, so a data read is valid one cycle after the access that moved the pointer. A queued write lands in memory no earlier than the second edge after the data write and can be read only after a later pointer load. The bench drives inputs just after a rising edge and samples in the middle of the cycle. A behavioural model, made of a word array and a write queue, is updated on each rising edge with the same ordering, and every cycle host_rdata is compared against it, together with hand-worked directed values.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  // Host register select codes
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PNR  = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  // Pointer register field positions (host visible)
  localparam int PTR_RCV_BIT  = 15;
  localparam int PTR_AINC_BIT = 14;
  localparam int PTR_RD_BIT   = 13;
  localparam int PTR_PEND_BIT = 11;
endpackage

// File: rtl/pmp_pkt_ram.sv
module pmp_pkt_ram #(
  parameter int AW    = 11,
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [8*LANES-1:0]   wdata,
  input  logic [LANES-1:0]     wbe,
  input  logic [AW-1:0]        raddr,
  output logic [8*LANES-1:0]   rdata
);
  localparam int DEPTH = 2 ** AW;

  // One byte-wide array per lane so byte enables map to block RAM
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];

    initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    end

    always_ff @(posedge clk) begin
      if (we && wbe[g]) mem[waddr] <= wdata[8*g +: 8];
      rdata[8*g +: 8] <= mem[raddr];
    end
  end
endmodule

// File: rtl/pmp_wr_pipe.sv
module pmp_wr_pipe #(
  parameter int DEPTH = 4,
  parameter int AW    = 11,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [AW-1:0]   push_addr,
  input  logic [DW-1:0]   push_data,
  input  logic [DW/8-1:0] push_be,
  input  logic            hold,
  output logic            pend,
  output logic            full,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_data,
  output logic [DW/8-1:0] mem_be
);
  localparam int QW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = QW + 1;

  logic [AW-1:0]   e_addr [DEPTH];
  logic [DW-1:0]   e_data [DEPTH];
  logic [DW/8-1:0] e_be   [DEPTH];
  logic [QW-1:0]   wr_idx, rd_idx;
  logic [CW-1:0]   count;
  logic            pop;

  assign pend = (count != '0);
  assign full = (count == CW'(DEPTH));
  assign pop  = pend && !hold;

  assign mem_we   = pop;
  assign mem_addr = e_addr[rd_idx];
  assign mem_data = e_data[rd_idx];
  assign mem_be   = e_be[rd_idx];

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[wr_idx] <= push_addr;
      e_data[wr_idx] <= push_data;
      e_be[wr_idx]   <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= (wr_idx == QW'(DEPTH - 1)) ? '0 : wr_idx + QW'(1);
      if (pop)  rd_idx <= (rd_idx == QW'(DEPTH - 1)) ? '0 : rd_idx + QW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R8
  AST_FULL_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (full && hold) |=> $stable(count)); // R8
  AST_DRAIN_ONE: assert property (@(posedge clk) disable iff (rst)
    (pend && !hold && !push) |=> (count == $past(count) - CW'(1))); // R7
  AST_HOLD_NO_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (hold && !push) |=> $stable(count)); // R7
endmodule

// File: rtl/pmp_ptr_ctrl.sv
module pmp_ptr_ctrl
  import pmp_pkg::*;
#(
  parameter int OFF_W = 11,
  parameter int PNR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel,
  input  logic             we,
  input  logic             re,
  input  logic             wide,
  input  logic             ld_rcv,
  input  logic             ld_ainc,
  input  logic             ld_rd,
  input  logic [OFF_W-1:0] ld_off,
  input  logic [PNR_W-1:0] ld_pnr,
  input  logic             q_full,
  output logic             rcv,
  output logic             ainc,
  output logic             rdir,
  output logic [OFF_W-1:0] off,
  output logic [PNR_W-1:0] pnr,
  output logic             rcv_nxt,
  output logic [OFF_W-3:0] word_nxt,
  output logic [PNR_W-1:0] pnr_nxt,
  output logic             push
);
  logic             ptr_wr, pnr_wr, rd_ok, adv;
  logic             ainc_nxt, rdir_nxt;
  logic [OFF_W-1:0] off_nxt, step;

  assign ptr_wr = we && (sel == SEL_PTR);
  assign pnr_wr = we && (sel == SEL_PNR);
  assign push   = we && (sel == SEL_DATA) && !rdir && !q_full;
  assign rd_ok  = re && (sel == SEL_DATA) && rdir;
  assign adv    = ainc && (push || rd_ok);
  assign step   = wide ? OFF_W'(4) : OFF_W'(2);

  always_comb begin
    rcv_nxt  = rcv;
    ainc_nxt = ainc;
    rdir_nxt = rdir;
    off_nxt  = off;
    pnr_nxt  = pnr;
    if (rst) begin
      rcv_nxt  = 1'b0;
      ainc_nxt = 1'b0;
      rdir_nxt = 1'b0;
      off_nxt  = '0;
      pnr_nxt  = '0;
    end else begin
      if (adv) off_nxt = off + step;
      if (ptr_wr) begin
        rcv_nxt  = ld_rcv;
        ainc_nxt = ld_ainc;
        rdir_nxt = ld_rd;
        off_nxt  = ld_off;
      end
      if (pnr_wr) pnr_nxt = ld_pnr;
    end
  end

  assign word_nxt = off_nxt[OFF_W-1:2];

  always_ff @(posedge clk) begin
    rcv  <= rcv_nxt;
    ainc <= ainc_nxt;
    rdir <= rdir_nxt;
    off  <= off_nxt;
    pnr  <= pnr_nxt;
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> (off == $past(ld_off)) && (rdir == $past(ld_rd))); // R3
  AST_STEP_NARROW: assert property (@(posedge clk) disable iff (rst)
    (re && sel == SEL_DATA && rdir && ainc && !wide && !we) |=> (off == $past(off) + OFF_W'(2))); // R4
  AST_NO_AINC_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ainc && !ptr_wr) |=> $stable(off)); // R4
  AST_WR_IN_READ_DIR: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_DATA && rdir && !re) |=> $stable(off)); // R9
endmodule

// File: rtl/pkt_mem_port.sv
module pkt_mem_port
  import pmp_pkg::*;
#(
  parameter int NUM_PKTS  = 4,
  parameter int PKT_BYTES = 2048,
  parameter int WQ_DEPTH  = 4,
  parameter int PNR_W     = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  host_sel,
  input  logic                        host_we,
  input  logic                        host_re,
  input  logic                        host_wide,
  input  logic [31:0]                 host_wdata,
  output logic [31:0]                 host_rdata,
  input  logic [$clog2(NUM_PKTS)-1:0] rx_head_pkt,
  input  logic                        mac_hold
);
  localparam int PKT_W = $clog2(NUM_PKTS);
  localparam int OFF_W = $clog2(PKT_BYTES);
  localparam int AW    = PKT_W + OFF_W - 2;

  logic             rcv, ainc, rdir, rcv_nxt, push, pend, full;
  logic [OFF_W-1:0] off;
  logic [OFF_W-3:0] word_nxt;
  logic [PNR_W-1:0] pnr, pnr_nxt;
  logic [PKT_W-1:0] cur_pkt, nxt_pkt;
  logic [31:0]      wr_word, ram_q, mem_data;
  logic [3:0]       wr_be, mem_be;
  logic             mem_we;
  logic [AW-1:0]    mem_addr;
  logic [15:0]      ptr_view;

  pmp_ptr_ctrl #(.OFF_W(OFF_W), .PNR_W(PNR_W)) u_ptr (
    .clk(clk), .rst(rst), .sel(host_sel), .we(host_we), .re(host_re), .wide(host_wide),
    .ld_rcv(host_wdata[PTR_RCV_BIT]), .ld_ainc(host_wdata[PTR_AINC_BIT]),
    .ld_rd(host_wdata[PTR_RD_BIT]), .ld_off(host_wdata[OFF_W-1:0]),
    .ld_pnr(host_wdata[PNR_W-1:0]), .q_full(full),
    .rcv(rcv), .ainc(ainc), .rdir(rdir), .off(off), .pnr(pnr),
    .rcv_nxt(rcv_nxt), .word_nxt(word_nxt), .pnr_nxt(pnr_nxt), .push(push)
  );

  // Target packet: receive-queue head or the numbered packet
  assign cur_pkt = rcv     ? rx_head_pkt : pnr[PKT_W-1:0];
  assign nxt_pkt = rcv_nxt ? rx_head_pkt : pnr_nxt[PKT_W-1:0];

  // Place a 16-bit write in the half chosen by offset bit 1
  always_comb begin
    if (host_wide) begin
      wr_word = host_wdata;
      wr_be   = 4'b1111;
    end else if (off[1]) begin
      wr_word = {host_wdata[15:0], 16'h0000};
      wr_be   = 4'b1100;
    end else begin
      wr_word = {16'h0000, host_wdata[15:0]};
      wr_be   = 4'b0011;
    end
  end

  pmp_wr_pipe #(.DEPTH(WQ_DEPTH), .AW(AW), .DW(32)) u_wq (
    .clk(clk), .rst(rst), .push(push), .push_addr({cur_pkt, off[OFF_W-1:2]}),
    .push_data(wr_word), .push_be(wr_be), .hold(mac_hold),
    .pend(pend), .full(full), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be)
  );

  // Read port addressed by the pointer's next value: prefetch lands with it
  pmp_pkt_ram #(.AW(AW), .LANES(4)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data), .wbe(mem_be),
    .raddr({nxt_pkt, word_nxt}), .rdata(ram_q)
  );

  always_comb begin
    ptr_view = '0;
    ptr_view[PTR_RCV_BIT]  = rcv;
    ptr_view[PTR_AINC_BIT] = ainc;
    ptr_view[PTR_RD_BIT]   = rdir;
    ptr_view[PTR_PEND_BIT] = pend;
    ptr_view[OFF_W-1:0]    = off;
  end

  always_comb begin
    case (host_sel)
      SEL_PTR:  host_rdata = {16'h0000, ptr_view};
      SEL_DATA: host_rdata = host_wide ? ram_q
                           : {16'h0000, (off[1] ? ram_q[31:16] : ram_q[15:0])};
      SEL_PNR:  host_rdata = 32'(pnr);
      default:  host_rdata = 32'h0;
    endcase
  end

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    full |-> !push); // R8
  AST_PEND_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
    push |=> pend); // R7
endmodule

// File: tb/test_pkt_mem_port.sv
module test_pkt_mem_port;
  localparam int CLK_PERIOD = 10;
  localparam int WQ = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  host_sel = 2'd3;
  logic        host_we = 1'b0, host_re = 1'b0, host_wide = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [1:0]  rx_head_pkt = 2'd0;
  logic        mac_hold = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_mem_port i_pkt_mem_port (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we), .host_re(host_re),
    .host_wide(host_wide), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_head_pkt(rx_head_pkt), .mac_hold(mac_hold)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mem [0:2047];
  logic [10:0] q_a[$];
  logic [31:0] q_d[$];
  logic [3:0]  q_b[$];
  logic        m_rcv, m_ainc, m_rd;
  logic [10:0] m_off;
  logic [5:0]  m_pnr;
  logic [31:0] m_dq;

  initial for (int i = 0; i < 2048; i++) m_mem[i] = 32'h0;

  always @(posedge clk) begin
    if (rst) begin
      m_rcv = 0; m_ainc = 0; m_rd = 0; m_off = 0; m_pnr = 0;
      q_a.delete(); q_d.delete(); q_b.delete();
      m_dq = m_mem[0];
    end else begin
      bit full;
      logic n_rcv, n_ainc, n_rd;
      logic [10:0] n_off, wa;
      logic [5:0]  n_pnr;
      logic [1:0]  pk;
      bit do_push;
      logic [31:0] pd;
      logic [3:0]  pb;
      full = (q_a.size() == WQ);
      n_rcv = m_rcv; n_ainc = m_ainc; n_rd = m_rd; n_off = m_off; n_pnr = m_pnr;
      do_push = 0; pd = 0; pb = 0;
      pk = m_rcv ? rx_head_pkt : m_pnr[1:0];
      wa = {pk, m_off[10:2]};
      if (host_we && host_sel == 2'd1 && !m_rd && !full) begin
        do_push = 1;
        if (host_wide) begin pd = host_wdata; pb = 4'hF; end
        else if (m_off[1]) begin pd = {host_wdata[15:0], 16'h0}; pb = 4'hC; end
        else begin pd = {16'h0, host_wdata[15:0]}; pb = 4'h3; end
        if (m_ainc) n_off = m_off + (host_wide ? 11'd4 : 11'd2);
      end
      if (host_re && host_sel == 2'd1 && m_rd && m_ainc)
        n_off = m_off + (host_wide ? 11'd4 : 11'd2);
      if (host_we && host_sel == 2'd0) begin
        n_rcv = host_wdata[15]; n_ainc = host_wdata[14]; n_rd = host_wdata[13];
        n_off = host_wdata[10:0];
      end
      if (host_we && host_sel == 2'd2) n_pnr = host_wdata[5:0];
      pk = n_rcv ? rx_head_pkt : n_pnr[1:0];
      m_dq = m_mem[{pk, n_off[10:2]}];
      if (q_a.size() > 0 && !mac_hold) begin
        for (int b = 0; b < 4; b++)
          if (q_b[0][b]) m_mem[q_a[0]][8*b +: 8] = q_d[0][8*b +: 8];
        void'(q_a.pop_front()); void'(q_d.pop_front()); void'(q_b.pop_front());
      end
      if (do_push) begin q_a.push_back(wa); q_d.push_back(pd); q_b.push_back(pb); end
      m_rcv = n_rcv; m_ainc = n_ainc; m_rd = n_rd; m_off = n_off; m_pnr = n_pnr;
    end
  end

  function automatic logic [31:0] model_rdata();
    case (host_sel)
      2'd0: return {16'h0, m_rcv, m_ainc, m_rd, 1'b0, (q_a.size() != 0), m_off};
      2'd1: return host_wide ? m_dq : {16'h0, (m_off[1] ? m_dq[31:16] : m_dq[15:0])};
      2'd2: return {26'h0, m_pnr};
      default: return 32'h0;
    endcase
  endfunction

  // Cycle-by-cycle comparison in mid-cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [31:0] e;
      e = model_rdata();
      checks++;
      if (host_rdata !== e) begin
        errors++;
        $display("FAIL model compare R1-model sel=%0d actual=%h expected=%h", host_sel, host_rdata, e);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] sel, input logic we, input logic re, input logic wide,
                     input logic [31:0] wd, output logic [31:0] rv);
    @(posedge clk); #1;
    host_sel = sel; host_we = we; host_re = re; host_wide = wide; host_wdata = wd;
    @(negedge clk); rv = host_rdata;
    @(posedge clk); #1;
    host_we = 0; host_re = 0; host_sel = 2'd3;
  endtask

  task automatic wr(input logic [1:0] sel, input logic wide, input logic [31:0] wd);
    logic [31:0] d;
    acc(sel, 1'b1, 1'b0, wide, wd, d);
  endtask

  task automatic rd(input logic [1:0] sel, input logic wide, output logic [31:0] v);
    acc(sel, 1'b0, 1'b1, wide, 32'h0, v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // Watchdog
  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset state
    rd(2'd0, 0, v); chk("R1 pointer after reset", v, 32'h0000);
    rd(2'd2, 0, v); chk("R1 pnr after reset", v, 32'h0);
    // R10 packet-number register
    wr(2'd2, 0, 32'hFFFF_FFFF);
    rd(2'd2, 0, v); chk("R10 pnr 6-bit load", v, 32'h3F);
    rd(2'd3, 0, v); chk("R10 unused select reads zero", v, 32'h0);
    wr(2'd2, 0, 32'h1);
    rd(2'd2, 0, v); chk("R10 pnr reload", v, 32'h1);
    // R3 pointer fields; bits 12 and 11 not stored
    wr(2'd0, 0, 32'h5800);
    rd(2'd0, 0, v); chk("R3 pointer load ignores bits 12/11", v, 32'h4000);
    // R7/R8 write queue with the MAC holding memory
    mac_hold = 1;
    wr(2'd1, 1, 32'hA1B2C3D4);
    wr(2'd1, 0, 32'h1111);
    wr(2'd1, 0, 32'h2222);
    rd(2'd0, 0, v); chk("R7 pending flag while queued", v, 32'h4808);
    wr(2'd1, 0, 32'h3333);
    wr(2'd1, 0, 32'h4444);
    rd(2'd0, 0, v); chk("R8 full queue drops write, no advance", v, 32'h480A);
    mac_hold = 0;
    idle(6);
    rd(2'd0, 0, v); chk("R7 queue drained", v, 32'h400A);
    // R5/R4 reads with auto-increment
    wr(2'd0, 0, 32'h6000);
    rd(2'd1, 1, v); chk("R5 first wide read after repoint", v, 32'hA1B2C3D4);
    rd(2'd1, 0, v); chk("R5 narrow low half", v, 32'h1111);
    rd(2'd1, 0, v); chk("R6 narrow write went to high half", v, 32'h2222);
    rd(2'd1, 0, v); chk("R5 narrow read next word", v, 32'h3333);
    rd(2'd1, 0, v); chk("R8 dropped write not stored", v, 32'h0000);
    rd(2'd0, 0, v); chk("R4 offset advanced by 4+2+2+2+2", v, 32'h600C);
    // R6 half write keeps other half
    wr(2'd0, 0, 32'h4006);
    wr(2'd1, 0, 32'h5555);
    idle(2);
    wr(2'd0, 0, 32'h2004);
    rd(2'd1, 1, v); chk("R6 other half untouched", v, 32'h5555_1111);
    rd(2'd1, 1, v); chk("R4 no auto-increment repeats word", v, 32'h5555_1111);
    rd(2'd0, 0, v); chk("R4 offset unchanged without auto-increment", v, 32'h2004);
    // R9 direction mismatch
    wr(2'd1, 1, 32'hDEAD_BEEF);
    idle(2);
    rd(2'd0, 0, v); chk("R9 write in read direction: no queue, no advance", v, 32'h2004);
    wr(2'd0, 0, 32'h2004);
    rd(2'd1, 1, v); chk("R9 write in read direction stored nothing", v, 32'h5555_1111);
    wr(2'd0, 0, 32'h4010);
    rd(2'd1, 1, v);
    rd(2'd0, 0, v); chk("R9 read in write direction does not advance", v, 32'h4010);
    // R2 receive-head selection
    rx_head_pkt = 2'd2;
    wr(2'd0, 0, 32'hC000);
    wr(2'd1, 1, 32'hCAFE_F00D);
    idle(2);
    wr(2'd2, 0, 32'h2);
    wr(2'd0, 0, 32'h6000);
    rd(2'd1, 1, v); chk("R2 receive head wrote packet 2", v, 32'hCAFE_F00D);
    rx_head_pkt = 2'd1;
    wr(2'd0, 0, 32'hE000);
    rd(2'd1, 1, v); chk("R2 receive head overrides pnr", v, 32'hA1B2C3D4);
    // R4 wrap at window end
    wr(2'd0, 0, 32'h67FC);
    rd(2'd1, 1, v);
    rd(2'd0, 0, v); chk("R4 wide wrap to 0", v, 32'h6000);
    wr(2'd0, 0, 32'h67FE);
    rd(2'd1, 0, v);
    rd(2'd0, 0, v); chk("R4 narrow wrap to 0", v, 32'h6000);
    // R5 wide read ignores low offset bits
    wr(2'd2, 0, 32'h1);
    wr(2'd0, 0, 32'h2002);
    rd(2'd1, 1, v); chk("R5 wide read ignores offset bit 1", v, 32'hA1B2C3D4);
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule